// File: doc/BRIEF.md
# Block Move Engine

This block performs a byte-block copy between two 24-bit locations, as used by a processor's block-move instructions. A caller supplies two bank bytes taken from the instruction's operands, the current 16-bit X, Y and accumulator values, a direction select, an index-width select and a one-cycle start pulse. The engine then reads and writes a byte-wide memory port until the requested run is copied.

The source location is the bank from the second operand byte joined to X. The destination is the bank from the first operand byte joined to Y. The run length is the accumulator plus one. X and Y step after every byte, upward or downward, and the accumulator counts down. When the run ends, the engine presents the updated X, Y and accumulator, along with the data bank value, and pulses a completion flag. The caller writes these values back into its register file.

Top module: `blkmove_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `mem_rd` and `mem_wr` are 0, and `x_out`, `y_out`, `c_out` and `dbank_out` are 0.
- R2: Each byte takes two cycles. In the read cycle `mem_rd`=1 and `mem_addr` = {`opnd2`, X}. In the write cycle, which follows at once, `mem_wr`=1 and `mem_addr` = {`opnd1`, Y}. The memory returns `mem_rdata` in the cycle after `mem_rd`.
- R3: A start with `c_in`=C copies exactly C+1 bytes (C=0 copies one byte). C decrements once per byte, so `c_out` is 16'hFFFF at completion.
- R4: With `dir_desc`=0, X and Y each increase by 1 after every byte, and each wraps modulo 2^16.
- R5: With `dir_desc`=1, X and Y each decrease by 1 after every byte, and each wraps modulo 2^16.
- R6: With `idx8`=1, the high bytes of X and Y are forced to zero at start and stay zero. The low bytes step and wrap within 8 bits (0xFF+1 gives 0x00, and 0x00-1 gives 0xFF).
- R7: `done` is high for exactly one cycle, in the cycle after the last write. If start is sampled at clock edge 0, `done` is high in cycle 2(C+1)+1 counted from that edge.
- R8: At completion `dbank_out` equals `opnd1`, the destination bank.
- R9: A `start` pulse while the engine is busy is ignored. The move in progress keeps its addresses, its data and its count.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle. `mem_wdata` in a write cycle equals the byte returned for the preceding read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a move (sampled while idle) |
| dir_desc | input | 1 | 0 = ascending, 1 = descending |
| idx8 | input | 1 | 1 = 8-bit index registers |
| opnd1 | input | 8 | First operand byte (destination bank) |
| opnd2 | input | 8 | Second operand byte (source bank) |
| x_in | input | 16 | Starting source address |
| y_in | input | 16 | Starting destination address |
| c_in | input | 16 | Byte count minus one |
| mem_addr | output | 24 | Byte memory address |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |
| x_out | output | 16 | Updated X |
| y_out | output | 16 | Updated Y |
| c_out | output | 16 | Updated accumulator |
| dbank_out | output | 8 | Data bank after the move |

## Verification
The case that is hardest to reach from the ports is a start pulse arriving in the middle of a move. The bench raises `start` for one cycle during the third cycle of a four-byte move, with different banks and indices on the inputs. The scoreboard's queued read and write addresses then show whether the stray pulse disturbed the move. Overlapping source and destination ranges, and 8-bit index wrap in both directions, are set up deliberately. A shadow memory in the bench predicts every written byte for these cases.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } mv_state_e;
endpackage

// File: rtl/blkmove_idx.sv
module blkmove_idx #(
    parameter int W  = 16,
    parameter int NW = 8
) (
    input  logic [W-1:0] cur,
    input  logic         desc,
    input  logic         narrow,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] NARROW_MASK = {{(W-NW){1'b0}}, {NW{1'b1}}};

    logic [W-1:0] step;

    always_comb begin
        step = desc ? (cur - 1'b1) : (cur + 1'b1);
        nxt  = narrow ? (step & NARROW_MASK) : step;
    end
endmodule

// File: rtl/blkmove_ctrl.sv
module blkmove_ctrl
    import blkmove_pkg::*;
#(
    parameter int IW = 16,
    parameter int BW = 8,
    parameter int DW = 8,
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_desc,
    input  logic          idx8,
    input  logic [BW-1:0] opnd1,
    input  logic [BW-1:0] opnd2,
    input  logic [IW-1:0] x_in,
    input  logic [IW-1:0] y_in,
    input  logic [IW-1:0] c_in,
    output logic [BW+IW-1:0] mem_addr,
    output logic          mem_rd,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          done,
    output logic [IW-1:0] x_out,
    output logic [IW-1:0] y_out,
    output logic [IW-1:0] c_out,
    output logic [BW-1:0] dbank_out
);
    localparam logic [IW-1:0] NARROW_MASK = {{(IW-NW){1'b0}}, {NW{1'b1}}};
    localparam int NIDX = 2;

    typedef struct packed {
        mv_state_e     st;
        logic [IW-1:0] x;
        logic [IW-1:0] y;
        logic [IW-1:0] c;
        logic [BW-1:0] sbank;
        logic [BW-1:0] dbank;
        logic          desc;
        logic          narrow;
    } mv_regs_t;

    mv_regs_t q, d;

    logic [IW-1:0] idx_cur [NIDX];
    logic [IW-1:0] idx_nxt [NIDX];

    assign idx_cur[0] = q.x;
    assign idx_cur[1] = q.y;

    for (genvar g = 0; g < NIDX; g++) begin : g_idx
        blkmove_idx #(.W(IW), .NW(NW)) u_step (
            .cur    (idx_cur[g]),
            .desc   (q.desc),
            .narrow (q.narrow),
            .nxt    (idx_nxt[g])
        );
    end

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st     = ST_READ;
                    d.x      = idx8 ? (x_in & NARROW_MASK) : x_in;
                    d.y      = idx8 ? (y_in & NARROW_MASK) : y_in;
                    d.c      = c_in;
                    d.sbank  = opnd2;
                    d.dbank  = opnd1;
                    d.desc   = dir_desc;
                    d.narrow = idx8;
                end
            end
            ST_READ: begin
                d.st = ST_WRITE;
            end
            ST_WRITE: begin
                d.x = idx_nxt[0];
                d.y = idx_nxt[1];
                d.c = q.c - 1'b1;
                d.st = (q.c == '0) ? ST_DONE : ST_READ;
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        mem_rd    = (q.st == ST_READ);
        mem_wr    = (q.st == ST_WRITE);
        mem_addr  = mem_rd ? {q.sbank, q.x} : {q.dbank, q.y};
        mem_wdata = mem_rdata;
        busy      = (q.st != ST_IDLE);
        done      = (q.st == ST_DONE);
        x_out     = q.x;
        y_out     = q.y;
        c_out     = q.c;
        dbank_out = q.dbank;
    end

    a_r10_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r2_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    a_r7_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_wr));

    a_r3_count_wrapped_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (c_out == {IW{1'b1}}));

    a_r9_banks_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |=> ($stable(q.sbank) && $stable(q.dbank) && $stable(q.desc)));

    a_r6_narrow_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.narrow) |-> ((x_out & ~NARROW_MASK) == '0 && (y_out & ~NARROW_MASK) == '0));
endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine #(
    parameter int IW = 16,
    parameter int BW = 8,
    parameter int DW = 8,
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_desc,
    input  logic          idx8,
    input  logic [BW-1:0] opnd1,
    input  logic [BW-1:0] opnd2,
    input  logic [IW-1:0] x_in,
    input  logic [IW-1:0] y_in,
    input  logic [IW-1:0] c_in,
    output logic [BW+IW-1:0] mem_addr,
    output logic          mem_rd,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          done,
    output logic [IW-1:0] x_out,
    output logic [IW-1:0] y_out,
    output logic [IW-1:0] c_out,
    output logic [BW-1:0] dbank_out
);
    blkmove_ctrl #(.IW(IW), .BW(BW), .DW(DW), .NW(NW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dir_desc  (dir_desc),
        .idx8      (idx8),
        .opnd1     (opnd1),
        .opnd2     (opnd2),
        .x_in      (x_in),
        .y_in      (y_in),
        .c_in      (c_in),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .done      (done),
        .x_out     (x_out),
        .y_out     (y_out),
        .c_out     (c_out),
        .dbank_out (dbank_out)
    );
endmodule

// File: tb/sim_blkmove_engine.sv
module sim_blkmove_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_desc = 1'b0;
    logic        idx8 = 1'b0;
    logic [7:0]  opnd1 = '0;
    logic [7:0]  opnd2 = '0;
    logic [15:0] x_in = '0;
    logic [15:0] y_in = '0;
    logic [15:0] c_in = '0;
    logic [23:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata = '0;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic        busy;
    logic        done;
    logic [15:0] x_out;
    logic [15:0] y_out;
    logic [15:0] c_out;
    logic [7:0]  dbank_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct packed {
        logic        is_wr;
        logic [23:0] addr;
        logic [7:0]  data;
    } sb_item_t;

    sb_item_t exp_q[$];
    logic [7:0] mem_a [logic [23:0]];
    logic [7:0] shadow [logic [23:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    blkmove_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_desc(dir_desc), .idx8(idx8),
        .opnd1(opnd1), .opnd2(opnd2), .x_in(x_in), .y_in(y_in), .c_in(c_in),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
        .x_out(x_out), .y_out(y_out), .c_out(c_out), .dbank_out(dbank_out)
    );

    function automatic logic [7:0] seed_byte(logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [15:0] stepv(logic [15:0] v, bit desc, bit n8);
        logic [15:0] s;
        s = desc ? v - 16'd1 : v + 16'd1;
        return n8 ? (s & 16'h00FF) : s;
    endfunction

    // memory model: data the cycle after the read strobe
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem_a.exists(mem_addr) ? mem_a[mem_addr] : seed_byte(mem_addr);
        if (mem_wr) mem_a[mem_addr] = mem_wdata;
    end

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // monitor: pops expected reads/writes
    always @(negedge clk) begin
        if (rst_n && (mem_rd || mem_wr)) begin
            sb_item_t it;
            check(!(mem_rd && mem_wr), "R10", "rd and wr together", {mem_rd, mem_wr}, 0);
            if (exp_q.size() == 0) begin
                check(0, "R3", "unexpected access", mem_addr, 0);
            end else begin
                it = exp_q.pop_front();
                check(it.is_wr == mem_wr, "R2", "access kind", mem_wr, it.is_wr);
                check(it.addr == mem_addr, it.is_wr ? "R2 dst" : "R2 src", "address", mem_addr, it.addr);
                if (mem_wr) check(it.data == mem_wdata, "R10", "write data", mem_wdata, it.data);
            end
        end
    end

    task automatic run_move(bit desc, bit n8, logic [7:0] b1, logic [7:0] b2,
                            logic [15:0] x, logic [15:0] y, logic [15:0] c,
                            bit poke, string tag);
        logic [15:0] xs, ys;
        int n, k;
        n = int'(c) + 1;
        xs = n8 ? (x & 16'h00FF) : x;
        ys = n8 ? (y & 16'h00FF) : y;
        for (int i = 0; i < n; i++) begin
            logic [23:0] sa, da;
            logic [7:0] v;
            sa = {b2, xs};
            da = {b1, ys};
            v = shadow.exists(sa) ? shadow[sa] : seed_byte(sa);
            shadow[da] = v;
            exp_q.push_back('{is_wr: 1'b0, addr: sa, data: 8'h00});
            exp_q.push_back('{is_wr: 1'b1, addr: da, data: v});
            xs = stepv(xs, desc, n8);
            ys = stepv(ys, desc, n8);
        end
        @(negedge clk);
        dir_desc = desc; idx8 = n8; opnd1 = b1; opnd2 = b2;
        x_in = x; y_in = y; c_in = c; start = 1'b1;
        k = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            k++;
            start = 1'b0;
            if (poke && k == 3) begin
                // R9: stray start mid-move with different operands
                start = 1'b1; opnd1 = 8'hEE; opnd2 = 8'hDD;
                x_in = 16'h7777; y_in = 16'h8888; c_in = 16'h0009; dir_desc = ~desc;
            end
        end while (!done && k < 4000);
        start = 1'b0;
        check(k == 2*n + 1, {tag, " R7"}, "done cycle", k, 2*n + 1);
        check(x_out == xs, {tag, desc ? " R5" : " R4"}, "x_out", x_out, xs);
        check(y_out == ys, {tag, desc ? " R5" : " R4"}, "y_out", y_out, ys);
        check(c_out == 16'hFFFF, {tag, " R3"}, "c_out", c_out, 16'hFFFF);
        check(dbank_out == b1, {tag, " R8"}, "dbank_out", dbank_out, b1);
        @(negedge clk);
        check(!done, {tag, " R7"}, "done width", done, 0);
        check(exp_q.size() == 0, {tag, " R3"}, "accesses left", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_rd && !mem_wr, "R1", "idle strobes",
              {busy, done, mem_rd, mem_wr}, 0);
        check(x_out == 0 && y_out == 0 && c_out == 0 && dbank_out == 0, "R1",
              "reset outputs", {x_out, y_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_move(1'b0, 1'b0, 8'h12, 8'h34, 16'h1000, 16'h2000, 16'd3, 1'b0, "asc");
        run_move(1'b1, 1'b0, 8'h40, 8'h40, 16'h3005, 16'h3007, 16'd2, 1'b0, "desc_overlap");
        run_move(1'b0, 1'b0, 8'h40, 8'h40, 16'h3000, 16'h3001, 16'd3, 1'b0, "asc_overlap");
        run_move(1'b0, 1'b1, 8'h01, 8'h02, 16'h12FE, 16'hAB10, 16'd2, 1'b0, "R6_asc8");
        run_move(1'b1, 1'b1, 8'h03, 8'h04, 16'hFF01, 16'h5500, 16'd2, 1'b0, "R6_desc8");
        run_move(1'b1, 1'b0, 8'h09, 8'h08, 16'h0000, 16'h0100, 16'd0, 1'b0, "single_R3");
        run_move(1'b0, 1'b0, 8'h21, 8'h22, 16'hFFFE, 16'h0040, 16'd3, 1'b1, "busy_R9");
        run_move(1'b0, 1'b0, 8'hA0, 8'hB0, 16'h0200, 16'h0300, 16'd1, 1'b0, "after_R9");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule